// File: doc/BRIEF.md
# Segment Texture Histogram Builder

This block accumulates texture statistics for one square tile of an 8-bit grey image. A producer first loads the tile into a local pixel store through a simple write port. A pulse on `start` then makes the block wipe the half of an external histogram RAM that belongs to the tile under test. It visits every pixel that has all eight neighbours in row-major order. For each one it presents the 3x3 neighbourhood to an external calculator and waits for a brightness and a contrast value in return.

Each returned value is reduced to one of 32 bins by dropping its low three bits. The block then adds one to the matching counter word of the histogram RAM through a read, an increment and a write-back. Brightness counters occupy words 64..95 and contrast counters words 96..127. Words 0..63 hold reference histograms owned by another unit, and this block never touches them. When the last interior pixel has been counted, `done` rises and stays high until the next `start`.

Top module: `seg_hist_builder`

## Requirements
- R1: While reset is held and right after it, `done`, `win_valid`, `hram_rd_en` and `hram_wr_en` are all 0.
- R2: A write with `pix_we`=1 stores `pix_wdata` at tile position row*40+col, with row and column counted from 0 at the top left. The window contents then reflect it.
- R3: After `start`, words 64..127 of the histogram RAM are written to 0 before any counter is incremented, so earlier contents never leak into the result.
- R4: Exactly 38x38 = 1444 windows are presented per run, one per interior pixel (rows 1..38, columns 1..38). The order is row-major, and border pixels are never a window centre.
- R5: `win_pixels` bits [8k+7:8k] carry the neighbourhood pixel at row offset k/3-1 and column offset k%3-1 from the centre, so k=4 is the centre pixel.
- R6: Once `win_valid` rises it stays high, and `win_pixels` stays unchanged, until a cycle in which `res_valid` is 1.
- R7: For each result, the word at 64 + (`res_bright` >> 3) grows by exactly one.
- R8: For each result, the word at 96 + (`res_contrast` >> 3) grows by exactly one.
- R9: Each counter update reads a word, and in the following cycle writes that same word with the returned value plus one; the RAM returns read data one cycle after `hram_rd_en`. Read and write are never asserted in the same cycle.
- R10: The histogram RAM is never read or written at any address below 64.
- R11: `done` rises after the final contrast write of a run and stays high with no RAM access and no window offered until the next `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_we | input | 1 | Pixel store write strobe |
| pix_waddr | input | 11 | Pixel position row*40+col |
| pix_wdata | input | 8 | Pixel grey level |
| start | input | 1 | Begin a run (accepted while idle) |
| done | output | 1 | Run complete, held until next start |
| win_valid | output | 1 | Neighbourhood offered to calculator |
| win_pixels | output | 72 | Nine 8-bit pixels, index k=3*dr+dc |
| res_valid | input | 1 | Calculator result strobe |
| res_bright | input | 8 | Brightness of the offered centre |
| res_contrast | input | 8 | Contrast of the offered centre |
| hram_rd_en | output | 1 | Histogram RAM read strobe |
| hram_wr_en | output | 1 | Histogram RAM write strobe |
| hram_addr | output | 7 | Histogram RAM word address |
| hram_wdata | output | 16 | Histogram RAM write data |
| hram_rdata | input | 16 | Histogram RAM read data, one cycle latency |

## Verification
The hardest case to reach from the ports is a stale RAM word surviving into a later run. Another is a calculator that answers late, so the window must be held across idle cycles. The bench therefore fills the whole histogram RAM with random garbage once and runs several tiles back to back without clearing anything itself. It answers each window after a random delay of zero to three cycles. Tile patterns include a flat 255 image, which drives every count into the top brightness bin and the bottom contrast bin, and a 0/255 checkerboard, which drives the top contrast bin.

// File: rtl/shb_pkg.sv
package shb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_FETCH = 3'd2,
        ST_CALC  = 3'd3,
        ST_RD_BR = 3'd4,
        ST_WR_BR = 3'd5,
        ST_RD_CT = 3'd6,
        ST_WR_CT = 3'd7
    } scan_st_e;
endpackage

// File: rtl/shb_pixel_ram.sv
module shb_pixel_ram #(
    parameter int DEPTH = 1600,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/shb_window_regs.sv
module shb_window_regs #(
    parameter int DW   = 8,
    parameter int TAPS = 9,
    localparam int SW  = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SW-1:0]    sel,
    input  logic [DW-1:0]    din,
    output logic [TAPS*DW-1:0] window
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic [DW-1:0] tap_q;
        logic          tap_en;
        assign tap_en = load && (sel == SW'(t));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      tap_q <= '0;
            else if (tap_en) tap_q <= din;
        end
        assign window[t*DW +: DW] = tap_q;
    end
endmodule

// File: rtl/shb_bin_addr.sv
module shb_bin_addr #(
    parameter int VW    = 8,
    parameter int AW    = 7,
    parameter int SHIFT = 3,
    parameter int BASE  = 64
) (
    input  logic [VW-1:0] value,
    output logic [AW-1:0] addr
);
    assign addr = AW'(BASE) + AW'(value >> SHIFT);
endmodule

// File: rtl/seg_hist_builder.sv
module seg_hist_builder
    import shb_pkg::*;
#(
    parameter int SEG_W     = 40,
    parameter int SEG_H     = 40,
    parameter int PIX_W     = 8,
    parameter int CNT_W     = 16,
    parameter int HAW       = 7,
    parameter int BIN_SHIFT = 3,
    parameter int BR_BASE   = 64,
    parameter int CT_BASE   = 96,
    localparam int PIX_N    = SEG_W * SEG_H,
    localparam int PAW      = $clog2(PIX_N),
    localparam int TAPS     = 9,
    localparam int SW       = $clog2(TAPS),
    localparam int NBINS    = 1 << (PIX_W - BIN_SHIFT),
    localparam int TWORDS   = 2 * NBINS,
    localparam int CLW      = $clog2(TWORDS),
    localparam int CW       = $clog2(SEG_W),
    localparam int RW       = $clog2(SEG_H)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pix_we,
    input  logic [PAW-1:0]        pix_waddr,
    input  logic [PIX_W-1:0]      pix_wdata,
    input  logic                  start,
    output logic                  done,
    output logic                  win_valid,
    output logic [TAPS*PIX_W-1:0] win_pixels,
    input  logic                  res_valid,
    input  logic [PIX_W-1:0]      res_bright,
    input  logic [PIX_W-1:0]      res_contrast,
    output logic                  hram_rd_en,
    output logic                  hram_wr_en,
    output logic [HAW-1:0]        hram_addr,
    output logic [CNT_W-1:0]      hram_wdata,
    input  logic [CNT_W-1:0]      hram_rdata
);
    typedef struct packed {
        scan_st_e         st;
        logic [CLW-1:0]   clr;
        logic [RW-1:0]    row;
        logic [CW-1:0]    col;
        logic [1:0]       wr;
        logic [1:0]       wc;
        logic [SW:0]      fidx;
        logic [PIX_W-1:0] bval;
        logic [PIX_W-1:0] cval;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             pix_re;
    logic [PAW-1:0]   pix_raddr;
    logic [PAW-1:0]   fetch_row;
    logic [PIX_W-1:0] pix_rdata;
    logic             cap_load;
    logic [SW-1:0]    cap_sel;
    logic [HAW-1:0]   br_addr, ct_addr;

    shb_pixel_ram #(.DEPTH(PIX_N), .DW(PIX_W)) u_pix (
        .clk(clk), .we(pix_we), .waddr(pix_waddr), .wdata(pix_wdata),
        .re(pix_re), .raddr(pix_raddr), .rdata(pix_rdata)
    );

    shb_window_regs #(.DW(PIX_W), .TAPS(TAPS)) u_win (
        .clk(clk), .rst_n(rst_n), .load(cap_load), .sel(cap_sel),
        .din(pix_rdata), .window(win_pixels)
    );

    shb_bin_addr #(.VW(PIX_W), .AW(HAW), .SHIFT(BIN_SHIFT), .BASE(BR_BASE)) u_br (
        .value(ctl_q.bval), .addr(br_addr)
    );

    shb_bin_addr #(.VW(PIX_W), .AW(HAW), .SHIFT(BIN_SHIFT), .BASE(CT_BASE)) u_ct (
        .value(ctl_q.cval), .addr(ct_addr)
    );

    // Address of the neighbourhood word selected by the (wr, wc) sub-counters.
    assign fetch_row = PAW'(ctl_q.row) + PAW'(ctl_q.wr) - PAW'(1);
    assign pix_raddr = fetch_row * PAW'(SEG_W) + PAW'(ctl_q.col) + PAW'(ctl_q.wc) - PAW'(1);
    assign cap_sel   = SW'(ctl_q.fidx - 1'b1);

    always_comb begin
        ctl_d      = ctl_q;
        pix_re     = 1'b0;
        cap_load   = 1'b0;
        hram_rd_en = 1'b0;
        hram_wr_en = 1'b0;
        hram_addr  = '0;
        hram_wdata = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_CLEAR;
                    ctl_d.clr  = '0;
                    ctl_d.done = 1'b0;
                end
            end
            ST_CLEAR: begin
                hram_wr_en = 1'b1;
                hram_addr  = HAW'(BR_BASE) + HAW'(ctl_q.clr);
                ctl_d.clr  = ctl_q.clr + 1'b1;
                if (ctl_q.clr == CLW'(TWORDS - 1)) begin
                    ctl_d.st   = ST_FETCH;
                    ctl_d.row  = RW'(1);
                    ctl_d.col  = CW'(1);
                    ctl_d.wr   = '0;
                    ctl_d.wc   = '0;
                    ctl_d.fidx = '0;
                end
            end
            ST_FETCH: begin
                // Read issued in cycle n lands in tap n-1 in cycle n+1.
                cap_load = (ctl_q.fidx != '0);
                if (ctl_q.fidx != (SW+1)'(TAPS)) begin
                    pix_re     = 1'b1;
                    ctl_d.fidx = ctl_q.fidx + 1'b1;
                    if (ctl_q.wc == 2'd2) begin
                        ctl_d.wc = 2'd0;
                        ctl_d.wr = ctl_q.wr + 2'd1;
                    end else begin
                        ctl_d.wc = ctl_q.wc + 2'd1;
                    end
                end else begin
                    ctl_d.st = ST_CALC;
                    ctl_d.wr = '0;
                    ctl_d.wc = '0;
                end
            end
            ST_CALC: begin
                if (res_valid) begin
                    ctl_d.bval = res_bright;
                    ctl_d.cval = res_contrast;
                    ctl_d.st   = ST_RD_BR;
                end
            end
            ST_RD_BR: begin
                hram_rd_en = 1'b1;
                hram_addr  = br_addr;
                ctl_d.st   = ST_WR_BR;
            end
            ST_WR_BR: begin
                hram_wr_en = 1'b1;
                hram_addr  = br_addr;
                hram_wdata = hram_rdata + 1'b1;
                ctl_d.st   = ST_RD_CT;
            end
            ST_RD_CT: begin
                hram_rd_en = 1'b1;
                hram_addr  = ct_addr;
                ctl_d.st   = ST_WR_CT;
            end
            ST_WR_CT: begin
                hram_wr_en = 1'b1;
                hram_addr  = ct_addr;
                hram_wdata = hram_rdata + 1'b1;
                ctl_d.fidx = '0;
                ctl_d.st   = ST_FETCH;
                if (ctl_q.col == CW'(SEG_W - 2)) begin
                    ctl_d.col = CW'(1);
                    if (ctl_q.row == RW'(SEG_H - 2)) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.row = ctl_q.row + 1'b1;
                    end
                end else begin
                    ctl_d.col = ctl_q.col + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign done      = ctl_q.done;
    assign win_valid = (ctl_q.st == ST_CALC);

    // R9: every counter write lands on the word read the cycle before.
    p_rmw_same_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WR_BR || ctl_q.st == ST_WR_CT)
            |-> ($past(hram_rd_en) && hram_addr == $past(hram_addr)));

    // R9: one RAM operation per cycle.
    p_single_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hram_rd_en && hram_wr_en));

    // R10: reference region untouched.
    p_ref_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hram_rd_en || hram_wr_en) |-> (hram_addr >= HAW'(BR_BASE)));

    // R6: window held until the calculator answers.
    p_window_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !res_valid) |=> (win_valid && $stable(win_pixels)));

    // R11: quiet while done.
    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!hram_rd_en && !hram_wr_en && !win_valid));

    // R11: done only rises right after the last contrast write.
    p_done_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(hram_wr_en));
endmodule

// File: tb/seg_hist_builder_tb_top.sv
module seg_hist_builder_tb_top;
    localparam int W = 40;
    localparam int H = 40;
    localparam int NI = (W - 2) * (H - 2);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_we;
    logic [10:0] pix_waddr;
    logic [7:0]  pix_wdata;
    logic        start;
    logic        done;
    logic        win_valid;
    logic [71:0] win_pixels;
    logic        res_valid;
    logic [7:0]  res_bright, res_contrast;
    logic        hram_rd_en, hram_wr_en;
    logic [6:0]  hram_addr;
    logic [15:0] hram_wdata;
    logic [15:0] hram_rdata;

    logic        tb_we;
    logic [6:0]  tb_addr;
    logic [15:0] tb_wdata;

    logic [7:0]  img [W*H];
    logic [15:0] hmem [128];
    logic [15:0] ref_snap [64];
    int          exp_h [128];

    int checks = 0;
    int fails = 0;
    int win_count;
    bit saw_overlap = 1'b0;
    bit saw_low = 1'b0;
    bit unstable = 1'b0;

    always #2 clk = ~clk;

    seg_hist_builder dut_i (
        .clk(clk), .rst_n(rst_n), .pix_we(pix_we), .pix_waddr(pix_waddr),
        .pix_wdata(pix_wdata), .start(start), .done(done),
        .win_valid(win_valid), .win_pixels(win_pixels), .res_valid(res_valid),
        .res_bright(res_bright), .res_contrast(res_contrast),
        .hram_rd_en(hram_rd_en), .hram_wr_en(hram_wr_en), .hram_addr(hram_addr),
        .hram_wdata(hram_wdata), .hram_rdata(hram_rdata)
    );

    // Histogram RAM model, one cycle read latency.
    always @(posedge clk) begin
        if (tb_we) hmem[tb_addr] <= tb_wdata;
        else if (hram_wr_en) hmem[hram_addr] <= hram_wdata;
        if (hram_rd_en) hram_rdata <= hmem[hram_addr];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (hram_rd_en && hram_wr_en) saw_overlap = 1'b1;
            if ((hram_rd_en || hram_wr_en) && hram_addr < 7'd64) saw_low = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] f_bright(input logic [71:0] w);
        int s = 0;
        for (int k = 0; k < 9; k++) if (k != 4) s += int'(w[8*k +: 8]);
        return 8'(s / 8);
    endfunction

    function automatic logic [7:0] f_contrast(input logic [71:0] w);
        logic [7:0] mx = 8'd0;
        logic [7:0] mn = 8'd255;
        for (int k = 0; k < 9; k++) begin
            if (w[8*k +: 8] > mx) mx = w[8*k +: 8];
            if (w[8*k +: 8] < mn) mn = w[8*k +: 8];
        end
        return mx - mn;
    endfunction

    function automatic logic [71:0] exp_win(input int n);
        logic [71:0] w;
        int r = 1 + n / (W - 2);
        int c = 1 + n % (W - 2);
        for (int k = 0; k < 9; k++) w[8*k +: 8] = img[(r - 1 + k / 3) * W + c - 1 + k % 3];
        return w;
    endfunction

    // Calculator model with random answer delay.
    initial begin
        logic [71:0] w0;
        int d;
        res_valid = 1'b0;
        res_bright = '0;
        res_contrast = '0;
        forever begin
            @(negedge clk);
            if (win_valid) begin
                w0 = win_pixels;
                check(w0 == exp_win(win_count), "R2/R4/R5 window", w0, exp_win(win_count));
                d = $urandom_range(0, 3);
                for (int i = 0; i < d; i++) begin
                    @(negedge clk);
                    if (!win_valid || win_pixels != w0) unstable = 1'b1;
                end
                res_bright = f_bright(w0);
                res_contrast = f_contrast(w0);
                res_valid = 1'b1;
                @(negedge clk);
                res_valid = 1'b0;
                win_count++;
            end
        end
    end

    task automatic fill_img(input int mode);
        for (int p = 0; p < W * H; p++) begin
            case (mode)
                0: img[p] = 8'($urandom);
                1: img[p] = 8'd255;
                2: img[p] = (((p / W) + (p % W)) % 2 == 0) ? 8'd0 : 8'd255;
                default: img[p] = 8'((p / W) * 6 + (p % W));
            endcase
        end
    endtask

    task automatic run_segment(input int mode);
        fill_img(mode);
        for (int p = 0; p < W * H; p++) begin
            @(negedge clk);
            pix_we = 1'b1;
            pix_waddr = 11'(p);
            pix_wdata = img[p];
        end
        @(negedge clk);
        pix_we = 1'b0;
        for (int a = 0; a < 128; a++) exp_h[a] = 0;
        for (int n = 0; n < NI; n++) begin
            exp_h[64 + int'(f_bright(exp_win(n)) >> 3)]++;
            exp_h[96 + int'(f_contrast(exp_win(n)) >> 3)]++;
        end
        win_count = 0;
        unstable = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R11 done cleared by start", 72'(done), 72'd0);
        while (!done) @(negedge clk);
        check(win_count == NI, "R4 window count", 72'(win_count), 72'(NI));
        for (int a = 64; a < 96; a++)
            check(hmem[a] == 16'(exp_h[a]), "R3/R7/R9 brightness bin", 72'(hmem[a]), 72'(exp_h[a]));
        for (int a = 96; a < 128; a++)
            check(hmem[a] == 16'(exp_h[a]), "R3/R8/R9 contrast bin", 72'(hmem[a]), 72'(exp_h[a]));
        for (int a = 0; a < 64; a++)
            check(hmem[a] == ref_snap[a], "R10 reference word", 72'(hmem[a]), 72'(ref_snap[a]));
        check(!unstable, "R6 window held", 72'(unstable), 72'd0);
        check(!saw_overlap, "R9 read/write overlap", 72'(saw_overlap), 72'd0);
        check(!saw_low, "R10 low address access", 72'(saw_low), 72'd0);
        repeat (5) @(negedge clk);
        check(done && !win_valid && !hram_rd_en && !hram_wr_en, "R11 done held quiet",
              {win_valid, hram_rd_en, hram_wr_en, done}, 72'b0001);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog: done=%0b expected 1", done);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0;
        pix_we = 1'b0;
        pix_waddr = '0;
        pix_wdata = '0;
        start = 1'b0;
        tb_we = 1'b0;
        tb_addr = '0;
        tb_wdata = '0;
        repeat (3) @(negedge clk);
        check(!done && !win_valid && !hram_rd_en && !hram_wr_en, "R1 reset outputs",
              {done, win_valid, hram_rd_en, hram_wr_en}, 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !win_valid && !hram_rd_en && !hram_wr_en, "R1 after reset",
              {done, win_valid, hram_rd_en, hram_wr_en}, 72'd0);
        // Random garbage in every word, reference half snapshotted.
        for (int a = 0; a < 128; a++) begin
            tb_we = 1'b1;
            tb_addr = 7'(a);
            tb_wdata = 16'($urandom);
            if (a < 64) ref_snap[a] = tb_wdata;
            @(negedge clk);
        end
        tb_we = 1'b0;
        run_segment(0);
        run_segment(1);
        run_segment(2);
        run_segment(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule